// File: doc/BRIEF.md
# Register-Fronted Grid Memory

This block is a small byte-wide random access store that is reached only through two internal registers: an address holding register and a data holding register. The cells sit in a square grid. The upper address field drives a one-hot row decoder and the lower field drives a one-hot column decoder. The cell where the active row line meets the active column line is the one read or written.

The host uses a four-bit command port. A fetch strobe starts a read sequence of three steps: address capture, decode, and cell-to-register copy. A store strobe starts a write sequence of four steps: address capture, data capture, decode, and register-to-cell write. The two load flags are honoured with a strobe, and also on their own while the block is idle. Each step takes one clock. A one-cycle completion pulse marks the end of every sequence. The data holding register is visible at all times, so the result of a fetch appears there.

Top module: `regfront_mem`

## Requirements
- R1: The address is ROW_BITS+COL_BITS wide (default 4, so 16 cells of 8 bits). The upper ROW_BITS select the row and the lower COL_BITS select the column. For example, address 9 (binary 1001) selects row 2 and column 1.
- R2: While a decoded transfer step is active, exactly one row line and exactly one column line are high. At all other times no line is high.
- R3: A fetch strobe taken in idle with the load-address flag high captures `addr_in` on that edge. The selected cell appears on `data_q` after the third rising edge, counted from and including the strobe edge, and `done` is high in that same cycle.
- R4: A store strobe taken in idle with both load flags high captures `addr_in` on the strobe edge and `data_in` on the next edge. The cell is written on the fourth edge, with `done` high after that edge and `data_q` showing the stored value.
- R5: The latency is 3 cycles for a fetch and 4 cycles for a store, whatever the address.
- R6: `done` is high for exactly one cycle per completed sequence.
- R7: Any command bit seen while a sequence is in progress is ignored. The address register, the data register and the cells are left unchanged by it. The cycle in which `done` is high counts as idle.
- R8: In idle with no strobe, `cmd_ld_addr` loads the address register and `cmd_ld_data` loads the data register, so `data_q` shows `data_in` one cycle later. If fetch and store strobes arrive together, the fetch wins and no cell is written.
- R9: A fetch or store whose load flags are low uses the address and data already held in the registers.
- R10: A synchronous active-high `rst` clears both registers, the decode lines, `done` and the sequencer. It does not change any cell.
- R11: A store changes only the cell at the crossing of the active lines. Every other cell keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_ld_addr | input | 1 | Load address register from `addr_in` |
| cmd_ld_data | input | 1 | Load data register from `data_in` |
| cmd_fetch | input | 1 | Start a read sequence |
| cmd_store | input | 1 | Start a write sequence |
| addr_in | input | ROW_BITS+COL_BITS | Address value |
| data_in | input | DATA_W | Data value |
| data_q | output | DATA_W | Data holding register |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that command bits are sampled only on rising edges. They also assume that, once a store has started, `data_in` holds its value through the edge after the strobe, because that is the edge on which the data step samples it. The stimulus changes every input only on falling edges. It keeps `data_in` steady from the store strobe until `done`. It raises each strobe for a single cycle, except where it deliberately raises strobes while the block is busy to check that they are ignored. Cell contents are never read before they have been written, so every expected value comes from the bench's own model of the stores it has issued.

// File: rtl/regfront_pkg.sv
package regfront_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DATA  = 3'd1,
    ST_DEC   = 3'd2,
    ST_READ  = 3'd3,
    ST_WRITE = 3'd4
  } seq_state_t;
endpackage

// File: rtl/rf_onehot_dec.sv
module rf_onehot_dec #(
  parameter int SEL_W = 2,
  localparam int LINES = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  output logic [LINES-1:0] hot
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign hot[i] = (sel == SEL_W'(i));
  end
endmodule

// File: rtl/rf_cell_grid.sv
module rf_cell_grid #(
  parameter int DATA_W = 8,
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  localparam int CELLS = ROWS * COLS
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ROWS-1:0]   row_hot,
  input  logic [COLS-1:0]   col_hot,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [CELLS*DATA_W-1:0] masked;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [DATA_W-1:0] q;
      logic              hit;
      assign hit = row_hot[r] & col_hot[c];
      always_ff @(posedge clk) begin
        if (wr_en && hit) q <= wdata;
      end
      assign masked[(r*COLS+c)*DATA_W +: DATA_W] = hit ? q : '0;
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < CELLS; k++) rdata = rdata | masked[k*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/rf_seq.sv
module rf_seq
  import regfront_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmd_ld_addr,
  input  logic cmd_ld_data,
  input  logic cmd_fetch,
  input  logic cmd_store,
  output logic idle,
  output logic mar_ld,
  output logic mdr_ld_ext,
  output logic dec_ld,
  output logic rd_step,
  output logic wr_step
);
  seq_state_t state_q, state_d;
  logic       is_wr_q, dflag_q;

  assign idle       = (state_q == ST_IDLE);
  assign mar_ld     = idle && cmd_ld_addr;
  assign mdr_ld_ext = (idle && cmd_ld_data && !cmd_fetch && !cmd_store) ||
                      (state_q == ST_DATA && dflag_q);
  assign dec_ld     = (state_q == ST_DEC);
  assign rd_step    = (state_q == ST_READ);
  assign wr_step    = (state_q == ST_WRITE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (cmd_fetch)      state_d = ST_DEC;
        else if (cmd_store) state_d = ST_DATA;
      end
      ST_DATA:  state_d = ST_DEC;
      ST_DEC:   state_d = is_wr_q ? ST_WRITE : ST_READ;
      ST_READ:  state_d = ST_IDLE;
      ST_WRITE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      is_wr_q <= 1'b0;
      dflag_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (idle && (cmd_fetch || cmd_store)) begin
        is_wr_q <= !cmd_fetch;
        dflag_q <= !cmd_fetch && cmd_ld_data;
      end
    end
  end
endmodule

// File: rtl/regfront_mem.sv
module regfront_mem #(
  parameter int DATA_W   = 8,
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  localparam int ADDR_W  = ROW_BITS + COL_BITS,
  localparam int ROWS    = 1 << ROW_BITS,
  localparam int COLS    = 1 << COL_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_ld_addr,
  input  logic              cmd_ld_data,
  input  logic              cmd_fetch,
  input  logic              cmd_store,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_q,
  output logic              done
);
  logic              idle, mar_ld, mdr_ld_ext, dec_ld, rd_step, wr_step;
  logic [ADDR_W-1:0] mar_q;
  logic [ROWS-1:0]   row_dec, row_hot;
  logic [COLS-1:0]   col_dec, col_hot;
  logic [DATA_W-1:0] cell_rd;
  logic              sel_valid;

  rf_seq u_seq (
    .clk(clk), .rst(rst),
    .cmd_ld_addr(cmd_ld_addr), .cmd_ld_data(cmd_ld_data),
    .cmd_fetch(cmd_fetch), .cmd_store(cmd_store),
    .idle(idle), .mar_ld(mar_ld), .mdr_ld_ext(mdr_ld_ext),
    .dec_ld(dec_ld), .rd_step(rd_step), .wr_step(wr_step)
  );

  rf_onehot_dec #(.SEL_W(ROW_BITS)) u_row_dec (
    .sel(mar_q[ADDR_W-1:COL_BITS]), .hot(row_dec)
  );

  rf_onehot_dec #(.SEL_W(COL_BITS)) u_col_dec (
    .sel(mar_q[COL_BITS-1:0]), .hot(col_dec)
  );

  rf_cell_grid #(.DATA_W(DATA_W), .ROWS(ROWS), .COLS(COLS)) u_grid (
    .clk(clk), .wr_en(wr_step), .row_hot(row_hot), .col_hot(col_hot),
    .wdata(data_q), .rdata(cell_rd)
  );

  assign sel_valid = rd_step | wr_step;

  always_ff @(posedge clk) begin
    if (rst) begin
      mar_q   <= '0;
      data_q  <= '0;
      row_hot <= '0;
      col_hot <= '0;
      done    <= 1'b0;
    end else begin
      if (mar_ld) mar_q <= addr_in;
      if (mdr_ld_ext)   data_q <= data_in;
      else if (rd_step) data_q <= cell_rd;
      if (dec_ld) begin
        row_hot <= row_dec;
        col_hot <= col_dec;
      end else if (sel_valid) begin
        row_hot <= '0;
        col_hot <= '0;
      end
      done <= sel_valid;
    end
  end
endmodule

// File: rtl/regfront_mem_chk.sv
module regfront_mem_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int ROWS   = 4,
  parameter int COLS   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_fetch,
  input logic              cmd_store,
  input logic              idle,
  input logic              sel_valid,
  input logic [ADDR_W-1:0] mar_q,
  input logic [ROWS-1:0]   row_hot,
  input logic [COLS-1:0]   col_hot,
  input logic [DATA_W-1:0] data_q,
  input logic              done
);
  a_r2_one_crossing: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> ($countones(row_hot) == 1 && $countones(col_hot) == 1));

  a_r2_lines_quiet: assert property (@(posedge clk) disable iff (rst)
    !sel_valid |-> (row_hot == '0 && col_hot == '0));

  a_r3_fetch_latency: assert property (@(posedge clk) disable iff (rst)
    (idle && cmd_fetch) |-> ##3 done);

  a_r4_store_latency: assert property (@(posedge clk) disable iff (rst)
    (idle && cmd_store && !cmd_fetch) |-> ##4 done);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_addr_frozen: assert property (@(posedge clk) disable iff (rst)
    !idle |=> $stable(mar_q));

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (data_q == '0 && !done && idle && mar_q == '0));
endmodule

bind regfront_mem regfront_mem_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ROWS(ROWS), .COLS(COLS)
) i_chk (
  .clk(clk), .rst(rst), .cmd_fetch(cmd_fetch), .cmd_store(cmd_store),
  .idle(idle), .sel_valid(sel_valid), .mar_q(mar_q),
  .row_hot(row_hot), .col_hot(col_hot), .data_q(data_q), .done(done)
);

// File: tb/test_regfront_mem.sv
module test_regfront_mem;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int NC = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_ld_addr = 1'b0, cmd_ld_data = 1'b0;
  logic          cmd_fetch = 1'b0, cmd_store = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] data_in = '0;
  logic [DW-1:0] data_q;
  logic          done;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] model [NC];

  always #2.5 clk = ~clk;

  regfront_mem i_regfront_mem (
    .clk(clk), .rst(rst), .cmd_ld_addr(cmd_ld_addr), .cmd_ld_data(cmd_ld_data),
    .cmd_fetch(cmd_fetch), .cmd_store(cmd_store), .addr_in(addr_in),
    .data_in(data_in), .data_q(data_q), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'((a * 37 + 11 + salt) ^ 8'h5A);
  endfunction

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < 12) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic do_fetch(input int a, input bit lda, input int exp_v);
    int lat;
    @(negedge clk);
    cmd_fetch = 1'b1; cmd_ld_addr = lda; addr_in = AW'(a);
    @(negedge clk);
    cmd_fetch = 1'b0; cmd_ld_addr = 1'b0;
    wait_done(lat);
    check(lat == 3, "R5 fetch latency", lat, 3);
    check(data_q == DW'(exp_v), "R3 fetch data", data_q, exp_v);
    @(negedge clk);
    check(!done, "R6 done width", done, 0);
  endtask

  task automatic do_store(input int a, input int v, input bit lda, input bit ldd);
    int lat;
    @(negedge clk);
    cmd_store = 1'b1; cmd_ld_addr = lda; cmd_ld_data = ldd;
    addr_in = AW'(a); data_in = DW'(v);
    @(negedge clk);
    cmd_store = 1'b0; cmd_ld_addr = 1'b0; cmd_ld_data = 1'b0;
    wait_done(lat);
    check(lat == 4, "R5 store latency", lat, 4);
    @(negedge clk);
    check(!done, "R6 done width", done, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(data_q == 0, "R10 reset data", data_q, 0);
    check(!done, "R10 reset done", done, 0);

    // R4 R1: fill every cell with a distinct value
    for (int a = 0; a < NC; a++) begin
      model[a] = pat(a, 0);
      do_store(a, model[a], 1'b1, 1'b1);
      check(data_q == model[a], "R4 data reg holds stored value", data_q, model[a]);
    end
    // R3 R1: read every cell back
    for (int a = 0; a < NC; a++) do_fetch(a, 1'b1, model[a]);

    // R11 R1: rewrite address 9 (row 2, column 1) only
    model[9] = 8'hC3;
    do_store(9, 8'hC3, 1'b1, 1'b1);
    for (int a = 0; a < NC; a++) do_fetch(a, 1'b1, model[a]);

    // R7: commands during a fetch are ignored
    @(negedge clk);
    cmd_fetch = 1'b1; cmd_ld_addr = 1'b1; addr_in = 4'd3;
    @(negedge clk);
    cmd_fetch = 1'b0; cmd_store = 1'b1; cmd_ld_data = 1'b1; addr_in = 4'd5; data_in = 8'hEE;
    @(negedge clk);
    cmd_store = 1'b0; cmd_ld_addr = 1'b0; cmd_ld_data = 1'b0;
    @(negedge clk);
    check(done == 1'b1, "R7 busy fetch completes on time", done, 1);
    check(data_q == model[3], "R7 busy fetch data", data_q, model[3]);
    do_fetch(0, 1'b0, model[3]);   // address register still 3
    do_fetch(5, 1'b1, model[5]);   // cell 5 untouched

    // R8: standalone data load visible on data_q
    @(negedge clk);
    cmd_ld_data = 1'b1; data_in = 8'h3C;
    @(negedge clk);
    cmd_ld_data = 1'b0;
    check(data_q == 8'h3C, "R8 standalone data load", data_q, 8'h3C);
    // R9: store without data load uses held data register
    model[12] = 8'h3C;
    do_store(12, 8'h99, 1'b1, 1'b0);
    check(data_q == 8'h3C, "R9 store kept held data", data_q, 8'h3C);
    do_fetch(12, 1'b1, model[12]);
    // R8 R9: standalone address load then fetch with flag low
    @(negedge clk);
    cmd_ld_addr = 1'b1; addr_in = 4'd7;
    @(negedge clk);
    cmd_ld_addr = 1'b0; addr_in = 4'd14;
    do_fetch(14, 1'b0, model[7]);
    // R8: fetch wins over store
    @(negedge clk);
    cmd_fetch = 1'b1; cmd_store = 1'b1; cmd_ld_addr = 1'b1; cmd_ld_data = 1'b1;
    addr_in = 4'd2; data_in = 8'h11;
    @(negedge clk);
    cmd_fetch = 1'b0; cmd_store = 1'b0; cmd_ld_addr = 1'b0; cmd_ld_data = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(done == 1'b1, "R8 fetch priority latency", done, 1);
    check(data_q == model[2], "R8 fetch priority data", data_q, model[2]);
    do_fetch(2, 1'b1, model[2]);

    // R10: reset keeps cells, clears registers
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(data_q == 0, "R10 data cleared", data_q, 0);
    check(!done, "R10 done cleared", done, 0);
    do_fetch(11, 1'b0, model[0]);  // address register cleared to 0

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule